// File: doc/BRIEF.md
# Configurable Output Logic Macrocell

This block is one output macrocell of a sum-of-products programmable logic device. It receives the sum term computed by the logic array and a per-cell output-enable term. It also receives two array-wide terms, one that clears the register at once and one that sets it on the next clock edge. From these it produces the drive value and the enable for a tri-state pad, plus a true/complement feedback pair that returns to the array.

A two-bit configuration word selects between a registered path and a combinatorial I/O path, and selects active-high or active-low output in either path. The clear and set terms act on the stored bit before the polarity stage, so the pad level after a clear depends on the polarity chosen. A test preload path lets a bench or tester force any register value on a clock edge, which reaches states that normal sequencing cannot. The pad is modelled as separate drive, enable and sense signals. The sense signal carries the level seen on the pad side of the buffer.

Top module: `olmc_cell`

## Requirements
- R1: `mode_cfg[1]` selects the path (0 registered, 1 combinatorial) and `mode_cfg[0]` selects polarity (1 active high, 0 active low), giving the codes 00 registered/low, 01 registered/high, 10 combinatorial/low, 11 combinatorial/high.
- R2: In registered mode the register loads `sum_term` on each rising clock edge, and `pad_o` shows the stored bit when active high and its inverse when active low.
- R3: While `ar_term` is high the stored bit is 0 at once, without waiting for a clock edge, and this overrides every other control.
- R4: When `sp_term` is high at a rising edge (and `ar_term` is low), the stored bit becomes 1. This overrides the preload and the sum term.
- R5: When `pl_en` is high at a rising edge, with `sp_term` and `ar_term` low, the stored bit takes `pl_val` instead of `sum_term`.
- R6: When `rst_n` is low at a rising edge, the stored bit becomes 0.
- R7: After a clear (R3 or R6), a registered active-low cell drives `pad_o` = 1 and a registered active-high cell drives `pad_o` = 0.
- R8: In registered mode `fb_true` is the inverted stored bit and `fb_comp` is the stored bit, and neither depends on `pad_i`.
- R9: In combinatorial mode `pad_o` is `sum_term` (inverted when active low) in the same cycle, `fb_true` equals `pad_i` and `fb_comp` equals its inverse.
- R10: `oe_cfg` selects the buffer enable: 00 follows `oe_term`, 01 holds `pad_oe` at 1, and 10 or 11 holds `pad_oe` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Synchronous active-low power-on clear |
| mode_cfg | input | 2 | Path and polarity selection |
| oe_cfg | input | 2 | Output-enable source selection |
| sum_term | input | 1 | Sum of the cell's product terms |
| oe_term | input | 1 | Output-enable product term |
| ar_term | input | 1 | Shared asynchronous clear term |
| sp_term | input | 1 | Shared synchronous set term |
| pl_en | input | 1 | Test preload strobe |
| pl_val | input | 1 | Test preload value |
| pad_i | input | 1 | Level on the pad side of the buffer |
| pad_o | output | 1 | Value driven towards the pad |
| pad_oe | output | 1 | Tri-state buffer enable |
| fb_true | output | 1 | Feedback to the array, true form |
| fb_comp | output | 1 | Feedback to the array, complement form |

## Verification
The hardest condition to reach is the clear taking effect between clock edges, while the set term and the preload are also pending. The stimulus raises `ar_term` half a period after an edge and samples `pad_o` before the next edge. It then releases the clear with `sp_term` and `pl_en` both still high, to show which one wins. A second difficult point is showing that the registered feedback ignores the pad. For this the bench drives `pad_i` opposite to the stored bit and checks `fb_true` and `fb_comp` against the register value, which is exposed through `pad_o`.

// File: rtl/olmc_pkg.sv
// Package: shared types and decode helpers for the output macrocell.
// Assumes the two-bit mode word and the two-bit enable word described in the brief.
package olmc_pkg;

    // Output-enable source selection.
    typedef enum logic [1:0] {
        OE_FROM_TERM = 2'b00,
        OE_FORCE_ON  = 2'b01,
        OE_FORCE_OFF = 2'b10,
        OE_OFF_ALT   = 2'b11
    } oe_sel_e;

    // Decoded cell mode.
    typedef struct packed {
        logic comb_path;   // 1: combinatorial I/O, 0: registered
        logic act_high;    // 1: true output, 0: inverted output
    } cell_mode_t;

    // Split the configuration word into path and polarity.
    function automatic cell_mode_t decode_mode(input logic [1:0] cfg);
        cell_mode_t m;
        m.comb_path = cfg[1];
        m.act_high  = cfg[0];
        return m;
    endfunction

endpackage

// File: rtl/olmc_mode_dec.sv
// Module: turns the raw configuration bits into decoded mode and enable selections.
// Assumes the configuration is static during normal operation.
module olmc_mode_dec
    import olmc_pkg::*;
(
    input  logic [1:0] mode_cfg,
    input  logic [1:0] oe_cfg,
    output cell_mode_t mode,
    output oe_sel_e    oe_sel
);

    // Decode the path/polarity word and the enable-source word.
    always_comb begin
        mode   = decode_mode(mode_cfg);
        oe_sel = oe_sel_e'(oe_cfg);
    end

endmodule

// File: rtl/olmc_state_reg.sv
// Module: the cell's storage bit. Priority, highest first: asynchronous clear,
// synchronous power-on clear, synchronous set, test preload, data input.
// Assumes ar_term is glitch-free, since it acts without a clock.
module olmc_state_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic ar_term,
    input  logic sp_term,
    input  logic pl_en,
    input  logic pl_val,
    input  logic d_in,
    output logic q
);

    // Storage bit with the full priority chain.
    always_ff @(posedge clk or posedge ar_term) begin
        if (ar_term)       q <= 1'b0;
        else if (!rst_n)   q <= 1'b0;
        else if (sp_term)  q <= 1'b1;
        else if (pl_en)    q <= pl_val;
        else               q <= d_in;
    end

    // R3: a held clear is seen as a zero bit at every edge
    a_r3_clear_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ar_term |-> (q == 1'b0));

    // R4: set wins over preload and data
    a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n || ar_term)
        sp_term |=> (q == 1'b1));

    // R5: preload wins over data when set is idle
    a_r5_preload_loads: assert property (@(posedge clk) disable iff (!rst_n || ar_term)
        (!sp_term && pl_en) |=> (q == $past(pl_val)));

endmodule

// File: rtl/olmc_io_path.sv
// Module: output multiplexer, polarity stage, enable selection and feedback source.
// Assumes pad_i reflects the level on the pad side of the tri-state buffer.
module olmc_io_path
    import olmc_pkg::*;
(
    input  cell_mode_t mode,
    input  oe_sel_e    oe_sel,
    input  logic       q,
    input  logic       sum_term,
    input  logic       oe_term,
    input  logic       pad_i,
    output logic       pad_o,
    output logic       pad_oe,
    output logic       fb_true,
    output logic       fb_comp
);

    logic pre_pol;   // value ahead of the polarity stage
    logic fb_src;    // selected feedback source

    // Pick registered or combinatorial data, then apply polarity.
    always_comb begin
        pre_pol = mode.comb_path ? sum_term : q;
        pad_o   = mode.act_high ? pre_pol : ~pre_pol;
    end

    // Select the buffer enable source.
    always_comb begin
        unique case (oe_sel)
            OE_FROM_TERM: pad_oe = oe_term;
            OE_FORCE_ON:  pad_oe = 1'b1;
            default:      pad_oe = 1'b0;
        endcase
    end

    // Feedback: inverted bit when registered, pad sense when combinatorial.
    always_comb begin
        fb_src  = mode.comb_path ? pad_i : ~q;
        fb_true = fb_src;
        fb_comp = ~fb_src;
    end

endmodule

// File: rtl/olmc_cell.sv
// Module: top of one output macrocell. Ties decode, storage and I/O path together.
// Assumes configuration inputs change only while the cell output is unused.
module olmc_cell
    import olmc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_cfg,
    input  logic [1:0] oe_cfg,
    input  logic       sum_term,
    input  logic       oe_term,
    input  logic       ar_term,
    input  logic       sp_term,
    input  logic       pl_en,
    input  logic       pl_val,
    input  logic       pad_i,
    output logic       pad_o,
    output logic       pad_oe,
    output logic       fb_true,
    output logic       fb_comp
);

    cell_mode_t mode;
    oe_sel_e    oe_sel;
    logic       q;

    olmc_mode_dec u_dec (
        .mode_cfg (mode_cfg),
        .oe_cfg   (oe_cfg),
        .mode     (mode),
        .oe_sel   (oe_sel)
    );

    olmc_state_reg u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .ar_term (ar_term),
        .sp_term (sp_term),
        .pl_en   (pl_en),
        .pl_val  (pl_val),
        .d_in    (sum_term),
        .q       (q)
    );

    olmc_io_path u_io (
        .mode     (mode),
        .oe_sel   (oe_sel),
        .q        (q),
        .sum_term (sum_term),
        .oe_term  (oe_term),
        .pad_i    (pad_i),
        .pad_o    (pad_o),
        .pad_oe   (pad_oe),
        .fb_true  (fb_true),
        .fb_comp  (fb_comp)
    );

    // R8: registered active-high feedback is the opposite of the pin value
    a_r8_reg_feedback: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_cfg[1] && mode_cfg[0]) |-> (fb_true != pad_o));

    // R9: combinatorial feedback follows the pad side
    a_r9_comb_feedback: assert property (@(posedge clk) disable iff (!rst_n)
        mode_cfg[1] |-> (fb_true == pad_i && fb_comp != pad_i));

    // R10: forced-off enable never drives the pad
    a_r10_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
        oe_cfg[1] |-> !pad_oe);

    // R7: registered active-low cell shows a high pin while clear is held
    a_r7_low_pol_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (ar_term && mode_cfg == 2'b00) |-> pad_o);

endmodule

// File: tb/tb_olmc_cell.sv
module tb_olmc_cell;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_cfg = 2'b01;
    logic [1:0] oe_cfg = 2'b00;
    logic       sum_term = 1'b0, oe_term = 1'b0, ar_term = 1'b0, sp_term = 1'b0;
    logic       pl_en = 1'b0, pl_val = 1'b0, pad_i = 1'b0;
    logic       pad_o, pad_oe, fb_true, fb_comp;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    olmc_cell dut (
        .clk(clk), .rst_n(rst_n), .mode_cfg(mode_cfg), .oe_cfg(oe_cfg),
        .sum_term(sum_term), .oe_term(oe_term), .ar_term(ar_term),
        .sp_term(sp_term), .pl_en(pl_en), .pl_val(pl_val), .pad_i(pad_i),
        .pad_o(pad_o), .pad_oe(pad_oe), .fb_true(fb_true), .fb_comp(fb_comp)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Advance through one rising edge and settle just after it.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic set_inputs();
        @(negedge clk);
    endtask

    // R6/R7: power-on clear seen through both polarities
    task automatic t_reset();
        set_inputs(); mode_cfg = 2'b01; sum_term = 1'b1; rst_n = 1'b0;
        tick();
        chk("R6 cleared, active high pin", pad_o, 1'b0);
        set_inputs(); mode_cfg = 2'b00;
        #1 chk("R7 cleared, active low pin", pad_o, 1'b1);
        set_inputs(); rst_n = 1'b1; sum_term = 1'b0; mode_cfg = 2'b01;
        tick();
    endtask

    // R1/R2: registered data in both polarities
    task automatic t_registered();
        set_inputs(); mode_cfg = 2'b01; sum_term = 1'b1;
        #1 chk("R2 no change before edge", pad_o, 1'b0);
        tick();
        chk("R2 registered high pin=q", pad_o, 1'b1);
        set_inputs(); mode_cfg = 2'b00;
        #1 chk("R1 code 00 inverts stored bit", pad_o, 1'b0);
        set_inputs(); sum_term = 1'b0;
        tick();
        chk("R2 registered low after load 0", pad_o, 1'b1);
        set_inputs(); mode_cfg = 2'b01;
    endtask

    // R8: registered feedback ignores the pad sense
    task automatic t_reg_feedback();
        set_inputs(); mode_cfg = 2'b01; sum_term = 1'b1; pad_i = 1'b0;
        tick();
        chk("R8 fb_true = ~q", fb_true, 1'b0);
        chk("R8 fb_comp = q", fb_comp, 1'b1);
        set_inputs(); pad_i = 1'b1;
        #1 chk("R8 pad_i ignored", fb_true, 1'b0);
    endtask

    // R3: clear acts between edges and overrides set and preload
    task automatic t_async_clear();
        set_inputs(); mode_cfg = 2'b01; sum_term = 1'b1;
        tick();
        chk("R3 precondition q=1", pad_o, 1'b1);
        set_inputs(); ar_term = 1'b1; sp_term = 1'b1; pl_en = 1'b1; pl_val = 1'b1;
        #1 chk("R3 cleared without edge", pad_o, 1'b0);
        tick();
        chk("R3 clear overrides set at edge", pad_o, 1'b0);
        set_inputs(); mode_cfg = 2'b00;
        #1 chk("R7 clear shows high on active low", pad_o, 1'b1);
        mode_cfg = 2'b01;
        set_inputs(); ar_term = 1'b0;
        tick();
        chk("R4 set wins after clear released", pad_o, 1'b1);
        set_inputs(); sp_term = 1'b0; pl_en = 1'b0;
    endtask

    // R4/R5: set over preload and data, preload over data
    task automatic t_set_preload();
        set_inputs(); mode_cfg = 2'b01; sum_term = 1'b0; rst_n = 1'b1;
        tick();
        chk("R2 load 0", pad_o, 1'b0);
        set_inputs(); sp_term = 1'b1; pl_en = 1'b1; pl_val = 1'b0;
        #1 chk("R4 set waits for edge", pad_o, 1'b0);
        tick();
        chk("R4 set over preload and data", pad_o, 1'b1);
        set_inputs(); sp_term = 1'b0; pl_en = 1'b1; pl_val = 1'b0; sum_term = 1'b1;
        tick();
        chk("R5 preload 0 over data 1", pad_o, 1'b0);
        set_inputs(); pl_val = 1'b1; sum_term = 1'b0;
        tick();
        chk("R5 preload 1 over data 0", pad_o, 1'b1);
        set_inputs(); pl_en = 1'b0;
        tick();
        chk("R2 data resumes", pad_o, 1'b0);
    endtask

    // R6: synchronous clear needs an edge
    task automatic t_sync_clear();
        set_inputs(); sum_term = 1'b1;
        tick();
        set_inputs(); rst_n = 1'b0;
        #1 chk("R6 waits for edge", pad_o, 1'b1);
        tick();
        chk("R6 cleared at edge", pad_o, 1'b0);
        set_inputs(); rst_n = 1'b1; sum_term = 1'b0;
        tick();
    endtask

    // R9: combinatorial path and pad feedback
    task automatic t_comb();
        set_inputs(); mode_cfg = 2'b11; sum_term = 1'b1; pad_i = 1'b1;
        #1 chk("R9 comb high follows sum", pad_o, 1'b1);
        chk("R9 fb_true = pad_i", fb_true, 1'b1);
        chk("R9 fb_comp = ~pad_i", fb_comp, 1'b0);
        mode_cfg = 2'b10;
        #1 chk("R9 comb low inverts sum", pad_o, 1'b0);
        pad_i = 1'b0; sum_term = 1'b0;
        #1 chk("R9 comb low sum 0", pad_o, 1'b1);
        chk("R9 fb_true follows pad 0", fb_true, 1'b0);
        set_inputs(); mode_cfg = 2'b01;
    endtask

    // R10: enable source selection
    task automatic t_oe();
        set_inputs(); oe_cfg = 2'b00; oe_term = 1'b1;
        #1 chk("R10 term 1", pad_oe, 1'b1);
        oe_term = 1'b0;
        #1 chk("R10 term 0", pad_oe, 1'b0);
        oe_cfg = 2'b01;
        #1 chk("R10 forced on", pad_oe, 1'b1);
        oe_cfg = 2'b10; oe_term = 1'b1;
        #1 chk("R10 forced off code 10", pad_oe, 1'b0);
        oe_cfg = 2'b11;
        #1 chk("R10 forced off code 11", pad_oe, 1'b0);
        oe_cfg = 2'b00;
    endtask

    initial begin
        t_reset();
        t_registered();
        t_reg_feedback();
        t_async_clear();
        t_set_preload();
        t_sync_clear();
        t_comb();
        t_oe();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                failures++;
                checks++;
                $display("FAIL watchdog expired actual=1 expected=0");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule